// File: doc/BRIEF.md
# Multi-Channel Interval Timer

This block is a bank of five independent interval timers behind a plain 32-bit register bus with a single write strobe and combinational read data. Each channel counts up from zero at a rate set by its own 8-bit prescaler. When the count reaches the channel's programmed limit, the channel raises a sticky expiry flag. In periodic mode the channel then starts over from zero. In one-shot mode it disarms itself.

Software programs a channel by writing its limit register and then its control word. The control word holds the prescale value, the mode, an interrupt mask bit and a run bit. The live count can be read at any time. All expiry flags share one status word, and software clears them by writing ones to that word. Each channel drives its own interrupt line, and a combined line is the OR of all five.

Top module: `tick_timer_bank`

## Requirements
- R1: While rst_n is low, every register is held at 0, all reads return 0 and every interrupt output is low; assertion of rst_n takes effect without waiting for a clock edge.
- R2: Channel n (0..4) has its control word at byte address 16n, its limit at 16n+4 and its live count at 16n+8. The flag word is at 0x60. In the control word, bits 7:0 hold the prescale, bits 28:27 hold the mode (01 periodic, any other value one-shot), bit 29 is the interrupt mask and bit 30 is run. All other control bits read as 0. Any other address reads 0 and ignores writes.
- R3: While running, the count advances by one once every (prescale+1) clock cycles and holds between those steps.
- R4: With limit C ≥ 1 and prescale P, a channel expires (its flag rises) exactly C·(P+1) clock edges after the edge that wrote run=1.
- R5: On expiry in periodic mode, the count returns to 0 and counting continues, so the next expiry follows another C·(P+1) edges.
- R6: On expiry in one-shot mode, the run bit clears and the count returns to 0 and stays there. Writing a new limit and setting run again starts a fresh interval.
- R7: The limit register keeps only bits 23:0 of the written value and reads back zero-extended. A write of 0xFF000003 therefore behaves as a limit of 3.
- R8: Any write to a control word resets that channel's prescaler and count to 0. Writing 0 to it stops the channel.
- R9: Writing 1 to bit n of the flag word clears flag n, and writing 0 leaves the flag unchanged. If an expiry and a clear of the same flag land in the same cycle, the flag ends up set.
- R10: chan_irq[n] is flag n AND the channel's interrupt mask bit, and irq_any is the OR of chan_irq. A flag is set on expiry even when the mask bit is 0.
- R11: Writes to a live count address do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| chan_irq | output | 5 | Per-channel masked interrupt |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
Two things can hit a flag in the same cycle: a channel's expiry and a software write-one-to-clear. The bench runs channel 0 periodically at a known prescale and counts edges from the arming write. It then times a clear write so that the write lands on the exact edge of the next expiry. The flag must read as set afterwards. A clear issued one edge earlier, where nothing collides, must leave the flag at 0.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  // control word field positions (software decodes these)
  localparam int CTL_MODE_LSB = 27;
  localparam int CTL_IE_BIT   = 29;
  localparam int CTL_RUN_BIT  = 30;
  localparam logic [1:0] MODE_PERIODIC = 2'b01;

  // word select inside a channel window
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_LIMIT = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;
endpackage

// File: rtl/tick_channel.sv
module tick_channel
  import tick_timer_pkg::*;
#(
  parameter int PSC_W  = 8,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              lim_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] lim_rd,
  output logic [DATA_W-1:0] cnt_rd,
  output logic              expire,
  output logic              irq_mask
);

  logic [PSC_W-1:0] pre_q, pre_d;
  logic [1:0]       mode_q, mode_d;
  logic             ie_q, ie_d;
  logic             run_q, run_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic             tick, hit, periodic;
  logic             cfg_ce, run_ce;

  // next-state logic
  always_comb begin
    periodic = (mode_q == MODE_PERIODIC);
    tick     = run_q && (psc_q == pre_q);
    cnt_inc  = CNT_W'(cnt_q + 1'b1);
    hit      = tick && (cnt_inc == lim_q);
    expire   = hit && !ctrl_we;

    pre_d  = pre_q;
    mode_d = mode_q;
    ie_d   = ie_q;
    run_d  = run_q;
    psc_d  = psc_q;
    cnt_d  = cnt_q;
    if (ctrl_we) begin
      pre_d  = wdata[PSC_W-1:0];
      mode_d = wdata[CTL_MODE_LSB +: 2];
      ie_d   = wdata[CTL_IE_BIT];
      run_d  = wdata[CTL_RUN_BIT];
      psc_d  = '0;
      cnt_d  = '0;
    end else if (run_q) begin
      psc_d = tick ? '0 : PSC_W'(psc_q + 1'b1);
      if (tick) begin
        cnt_d = hit ? '0 : cnt_inc;
        if (hit && !periodic) run_d = 1'b0;
      end
    end
    lim_d = lim_we ? wdata[CNT_W-1:0] : lim_q;

    cfg_ce = ctrl_we;
    run_ce = ctrl_we || run_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      mode_q <= '0;
      ie_q   <= 1'b0;
    end else if (cfg_ce) begin
      pre_q  <= pre_d;
      mode_q <= mode_d;
      ie_q   <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      psc_q <= '0;
      cnt_q <= '0;
    end else if (run_ce) begin
      run_q <= run_d;
      psc_q <= psc_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (lim_we) lim_q <= lim_d;
  end

  // read views
  always_comb begin
    ctrl_rd                      = '0;
    ctrl_rd[PSC_W-1:0]           = pre_q;
    ctrl_rd[CTL_MODE_LSB +: 2]   = mode_q;
    ctrl_rd[CTL_IE_BIT]          = ie_q;
    ctrl_rd[CTL_RUN_BIT]         = run_q;
    lim_rd                       = DATA_W'(lim_q);
    cnt_rd                       = DATA_W'(cnt_q);
  end

  assign irq_mask = ie_q;

  // R3: the count only moves on a prescaler step or a control write
  a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_we) |=> $stable(cnt_q));

  // R6: one-shot expiry disarms and zeroes the count
  a_r6_oneshot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> (!run_q && cnt_q == '0));

  // R5: periodic expiry keeps running from zero
  a_r5_periodic_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (run_q && cnt_q == '0));

endmodule

// File: rtl/tick_flags.sv
module tick_flags #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] expire,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic [NUM_CH-1:0] irq_mask,
  output logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] chan_irq
);

  logic [NUM_CH-1:0] flags_q, flags_d, clr_eff;
  logic              flags_ce;

  always_comb begin
    clr_eff  = clr_we ? clr_mask : '0;
    flags_d  = (flags_q & ~clr_eff) | expire;  // a new expiry beats a clear
    flags_ce = clr_we || (|expire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_ce) flags_q <= flags_d;
  end

  assign flags    = flags_q;
  assign chan_irq = flags_q & irq_mask;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R9: an expiry always leaves its flag set, even under a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> flags_q[i]);
    // R9: a clear with no competing expiry drops the flag
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_mask[i] && !expire[i]) |=> !flags_q[i]);
  end

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int          NUM_CH    = 5,
  parameter int          PSC_W     = 8,
  parameter int          CNT_W     = 24,
  parameter int          ADDR_W    = 7,
  parameter int          DATA_W    = 32,
  parameter int          CH_STRIDE = 16,
  parameter logic [6:0]  FLAG_ADDR = 7'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] chan_irq,
  output logic              irq_any
);

  localparam int STRIDE_SH = $clog2(CH_STRIDE);
  localparam int CIDX_W    = ADDR_W - STRIDE_SH;

  logic [CIDX_W-1:0] ch_idx;
  logic [1:0]        sel;
  logic              aligned, flag_hit;

  logic [NUM_CH-1:0] ch_hit, ctrl_we, lim_we, expire, irq_mask, flags;
  logic [DATA_W-1:0] ctrl_rd [NUM_CH];
  logic [DATA_W-1:0] lim_rd  [NUM_CH];
  logic [DATA_W-1:0] cnt_rd  [NUM_CH];

  always_comb begin
    ch_idx   = bus_addr[ADDR_W-1:STRIDE_SH];
    sel      = bus_addr[3:2];
    aligned  = (bus_addr[1:0] == 2'b00) && (bus_addr[STRIDE_SH-1:4] == '0 || STRIDE_SH <= 4);
    flag_hit = (bus_addr == ADDR_W'(FLAG_ADDR));
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_hit[i]  = aligned && (ch_idx == CIDX_W'(i));
    assign ctrl_we[i] = bus_wen && ch_hit[i] && (sel == SEL_CTRL);
    assign lim_we[i]  = bus_wen && ch_hit[i] && (sel == SEL_LIMIT);

    tick_channel #(
      .PSC_W (PSC_W),
      .CNT_W (CNT_W),
      .DATA_W(DATA_W)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (ctrl_we[i]),
      .lim_we  (lim_we[i]),
      .wdata   (bus_wdata),
      .ctrl_rd (ctrl_rd[i]),
      .lim_rd  (lim_rd[i]),
      .cnt_rd  (cnt_rd[i]),
      .expire  (expire[i]),
      .irq_mask(irq_mask[i])
    );
  end

  tick_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .clr_we  (bus_wen && flag_hit),
    .clr_mask(bus_wdata[NUM_CH-1:0]),
    .irq_mask(irq_mask),
    .flags   (flags),
    .chan_irq(chan_irq)
  );

  assign irq_any = |chan_irq;

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        case (sel)
          SEL_CTRL:  bus_rdata = ctrl_rd[i];
          SEL_LIMIT: bus_rdata = lim_rd[i];
          SEL_COUNT: bus_rdata = cnt_rd[i];
          default:   bus_rdata = '0;
        endcase
      end
    end
    if (flag_hit) bus_rdata = DATA_W'(flags);
  end

  // R10: the combined line follows the per-channel lines one for one
  a_r10_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq == '0) |-> !irq_any);

endmodule

// File: tb/tick_timer_bank_bench.sv
`timescale 1ns/100ps
module tick_timer_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wen;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [4:0]  chan_irq;
  logic        irq_any;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  tick_timer_bank u_tick_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_irq(chan_irq), .irq_any(irq_any)
  );

  // {address, write data, expected read-back}
  localparam logic [70:0] VEC [0:8] = '{
    {7'h00, 32'hBFFF_FFFF, 32'h3800_00FF},  // R2 control fields only
    {7'h14, 32'hFFFF_FFFF, 32'h00FF_FFFF},  // R7 limit keeps 24 bits
    {7'h28, 32'h0000_1234, 32'h0000_0000},  // R11 count not writable
    {7'h30, 32'h2000_0005, 32'h2000_0005},  // R2
    {7'h44, 32'h0000_0010, 32'h0000_0010},  // R2
    {7'h0C, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 hole in window
    {7'h70, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 above map
    {7'h50, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 no sixth channel
    {7'h60, 32'h0000_001F, 32'h0000_0000}   // R9 clear of empty flags
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called just after a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.2;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    rd(7'h00, v); check("R1 ctrl0", v, 0);
    rd(7'h44, v); check("R1 limit4", v, 0);
    rd(7'h60, v); check("R1 flags", v, 0);
    check("R1 irq", {26'd0, irq_any, chan_irq}, 0);

    // table walk: write then read back
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][70:64], VEC[i][63:32]);
      rd(VEC[i][70:64], v);
      check("R2/R7/R11 table", v, VEC[i][31:0]);
    end

    // ch0 periodic, limit 4, prescale 2 -> expiry every 12 edges
    wr(7'h04, 32'd4);
    wr(7'h00, 32'h6800_0002);           // arming edge E
    wait_n(6);  rd(7'h08, v); check("R3 count at E+6", v, 2);
    wait_n(5);  check("R4 no irq at E+11", {31'd0, chan_irq[0]}, 0);
    rd(7'h08, v); check("R3 count at E+11", v, 3);
    wait_n(1);  check("R4 irq at E+12", {31'd0, chan_irq[0]}, 1);
    rd(7'h60, v); check("R4 flag word", v, 1);
    rd(7'h08, v); check("R5 count back to 0", v, 0);
    wr(7'h60, 32'd1);                   // clear at E+13
    check("R9 clear", {31'd0, chan_irq[0]}, 0);
    wait_n(10); check("R5 no irq at E+23", {31'd0, chan_irq[0]}, 0);
    wait_n(1);  check("R5 irq at E+24", {31'd0, chan_irq[0]}, 1);
    wr(7'h60, 32'd1);                   // clear at E+25
    wait_n(10);
    wr(7'h60, 32'd1);                   // clear at E+36, same edge as expiry
    rd(7'h60, v); check("R9 set beats clear", v & 32'h1, 1);
    wr(7'h60, 32'd0);
    rd(7'h60, v); check("R9 zero write no effect", v & 32'h1, 1);
    wr(7'h00, 32'd0);                   // R8 stop
    wr(7'h60, 32'd1);
    wait_n(20);
    rd(7'h08, v); check("R8 stopped count", v, 0);
    check("R8 no irq after stop", {31'd0, chan_irq[0]}, 0);

    // ch1 one-shot, limit 3, prescale 0
    wr(7'h14, 32'd3);
    wr(7'h10, 32'h6000_0000);
    wait_n(2);  check("R6 no irq at E+2", {31'd0, chan_irq[1]}, 0);
    wait_n(1);  check("R6 irq at E+3", {31'd0, chan_irq[1]}, 1);
    rd(7'h10, v); check("R6 run cleared", v, 32'h2000_0000);
    rd(7'h18, v); check("R6 count zero", v, 0);
    wait_n(10); rd(7'h18, v); check("R6 count stays", v, 0);
    wr(7'h60, 32'd2);
    wait_n(10); check("R6 no second expiry", {31'd0, chan_irq[1]}, 0);
    wr(7'h14, 32'd2);
    wr(7'h10, 32'h6000_0000);           // re-arm
    wait_n(1);  check("R6 re-arm early", {31'd0, chan_irq[1]}, 0);
    wait_n(1);  check("R6 re-arm expiry", {31'd0, chan_irq[1]}, 1);
    wr(7'h60, 32'd2);

    // ch2 expiry with mask off
    wr(7'h24, 32'd2);
    wr(7'h20, 32'h4000_0000);
    wait_n(2);
    rd(7'h60, v); check("R10 flag without mask", v, 32'h4);
    check("R10 masked lines", {26'd0, irq_any, chan_irq}, 0);
    wr(7'h20, 32'h2000_0000);
    check("R10 unmasked lines", {26'd0, irq_any, chan_irq}, {26'd0, 1'b1, 5'b00100});
    wr(7'h60, 32'd4);
    check("R10 any low after clear", {31'd0, irq_any}, 0);

    // ch3 control rewrite and count writes
    wr(7'h34, 32'd100);
    wr(7'h30, 32'h4800_0000);
    wait_n(10); rd(7'h38, v); check("R3 count ch3", v, 10);
    wr(7'h30, 32'h4800_0000);
    rd(7'h38, v); check("R8 rewrite zeroes count", v, 0);
    wait_n(5);  rd(7'h38, v); check("R8 counts again", v, 5);
    wr(7'h38, 32'd50);
    rd(7'h38, v); check("R11 count write ignored", v, 6);
    wr(7'h30, 32'd0);
    wait_n(5);  rd(7'h38, v); check("R8 zero write stops", v, 0);

    // ch4 limit above 24 bits
    wr(7'h44, 32'hFF00_0003);
    rd(7'h44, v); check("R7 upper bits dropped", v, 3);
    wr(7'h40, 32'h6000_0000);
    wait_n(2);  check("R7 no irq early", {31'd0, chan_irq[4]}, 0);
    wait_n(1);  check("R7 expiry at 3", {31'd0, chan_irq[4]}, 1);
    wr(7'h60, 32'h10);

    // R1 reset while running
    wr(7'h04, 32'd5);
    wr(7'h00, 32'h6800_0000);
    wait_n(7);
    check("R1 pre-reset irq", {31'd0, irq_any}, 1);
    rst_n = 1'b0;
    #1;
    check("R1 async irq clear", {26'd0, irq_any, chan_irq}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    rd(7'h00, v); check("R1 ctrl after reset", v, 0);
    rd(7'h04, v); check("R1 limit after reset", v, 0);
    rd(7'h60, v); check("R1 flags after reset", v, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule